// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox

This block lets each of four processor cores ring an interrupt on any core, itself included, and hand over a 31-bit message with it. Every ordered pair (source, destination) owns one 32-bit message word. The source reaches the word through its initiator window and the destination reaches the same storage through its target window. Setting the top bit of the word marks it busy and latches a doorbell flag at the destination. The destination acknowledges by writing a 1 to that top bit. The whole word then returns to zero and a completion flag can be latched back at the source.

Each core has its own register port and sees only its own window. An access is accepted in the cycle it is presented, and there is no back-pressure. A read returns its data one cycle later. Each core has two 8-bit masks that decide which other cores may set its doorbell flags and its completion flags. The core's interrupt line is the OR of its pending flags. A 30-bit extension word per pair carries extra data and has no side effects.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, every readable register in every window reads zero and all `irq` outputs are low.
- R2: A word stored by core s at its offset {grp=1, idx=d} reads back unchanged at core d offset {grp=0, idx=s}, and also at core s offset {grp=1, idx=d}. Read data appears on `bus_rdata` one cycle after the request.
- R3: An initiator write with bit 31 set, to a word whose bit 31 is clear, latches doorbell flag s (status bit s) at core d, provided bit s of core d's busy mask is set. `irq[d]` rises in the cycle after the write.
- R4: A target write with bit 31 set clears the whole shared word to zero. A target write with bit 31 clear has no effect.
- R5: An acknowledge by core d of pair (s, d) latches completion flag d (status bit 4+d) at core s, provided bit d of core s's done mask is set.
- R6: A clear mask bit blocks its flag from being set. A write of bit 31 to a word that is already busy does not ring again. The mask registers are at offset {4, 0} for busy and {4, 1} for done, and they read back as written.
- R7: The extension word holds 30 bits. It is written by core s at {grp=2, idx=d} or by core d at {grp=3, idx=s}, and it reads back through either view with bits 31:30 as zero. Writing it raises no flag and leaves the message word alone.
- R8: The status register at {4, 2} shows the doorbell flags in bits 3:0 and the completion flags in bits 7:4. Writing 1s to it clears those flags. A flag that is set in the same cycle as a clear stays set. `irq[c]` is high exactly while core c has any flag pending.
- R9: If an initiator write and an acknowledge reach the same pair in the same cycle, the word becomes zero, no doorbell is latched, and completion follows R5.
- R10: The offset is {grp[2:0], idx[1:0]}. Group values 5 to 7, and the control-group index 3, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | NCORE | Per-core access request |
| bus_we | input | NCORE | Per-core write enable (1 = write) |
| bus_addr | input | NCORE*OFFW | Per-core word offset {grp, idx} |
| bus_wdata | input | NCORE*DW | Per-core write data |
| bus_rdata | output | NCORE*DW | Per-core read data, valid one cycle after a read request |
| irq | output | NCORE | Per-core interrupt, level |

## Verification
The bench sweeps all sixteen pairs, self pairs included. A design that mixed up source and destination would put the data or the flag on the wrong core. For a self pair it would also get the doorbell and completion bits tangled in one status word. Further tests drive an initiator write and an acknowledge into one pair in the same cycle, and a flag set together with a status clear. A design with the wrong priority would either keep a stale busy word or lose a doorbell. Masked senders, re-rings of a busy word, and target writes without bit 31 would all show up as spurious flags or corrupted words if handled wrongly.

// File: rtl/doorbell_mbox_pkg.sv
package doorbell_mbox_pkg;
  typedef enum logic [2:0] {
    GRP_TGT   = 3'd0,
    GRP_INIT  = 3'd1,
    GRP_XINIT = 3'd2,
    GRP_XTGT  = 3'd3,
    GRP_CTRL  = 3'd4
  } grp_e;

  localparam int CTL_BUSY = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_STAT = 2;
endpackage

// File: rtl/doorbell_mbox_pair.sv
module doorbell_mbox_pair #(
  parameter int DW   = 32,
  parameter int EXTW = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_wr,
  input  logic [DW-1:0]   init_data,
  input  logic            tgt_wr,
  input  logic            tgt_top,
  input  logic            xinit_wr,
  input  logic            xtgt_wr,
  input  logic [EXTW-1:0] tgt_ext,
  output logic [DW-1:0]   msg_o,
  output logic [EXTW-1:0] ext_o,
  output logic            ring_o,
  output logic            ack_o
);
  logic [DW-1:0]   msg_q;
  logic [EXTW-1:0] ext_q;

  // acknowledge has priority over a same-cycle initiator write
  assign ack_o  = tgt_wr & tgt_top;
  assign ring_o = init_wr & init_data[DW-1] & ~msg_q[DW-1] & ~ack_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
      ext_q <= '0;
    end else begin
      if (ack_o)        msg_q <= '0;
      else if (init_wr) msg_q <= init_data;
      if (xtgt_wr)       ext_q <= tgt_ext;
      else if (xinit_wr) ext_q <= init_data[EXTW-1:0];
    end
  end

  assign msg_o = msg_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/doorbell_mbox_core.sv
module doorbell_mbox_core #(
  parameter int NCORE = 4,
  parameter int MASKW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORE-1:0]   ring_in,
  input  logic [NCORE-1:0]   ack_in,
  input  logic               busy_wr,
  input  logic               done_wr,
  input  logic               stat_wr,
  input  logic [MASKW-1:0]   mask_data,
  input  logic [2*NCORE-1:0] clr_data,
  output logic [MASKW-1:0]   busy_mask_o,
  output logic [MASKW-1:0]   done_mask_o,
  output logic [NCORE-1:0]   db_pend_o,
  output logic [NCORE-1:0]   cp_pend_o,
  output logic               irq_o
);
  logic [MASKW-1:0] busy_q, done_q;
  logic [NCORE-1:0] db_q, cp_q, db_clr, cp_clr;

  assign db_clr = stat_wr ? clr_data[NCORE-1:0]       : '0;
  assign cp_clr = stat_wr ? clr_data[2*NCORE-1:NCORE] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      done_q <= '0;
      db_q   <= '0;
      cp_q   <= '0;
    end else begin
      if (busy_wr) busy_q <= mask_data;
      if (done_wr) done_q <= mask_data;
      // new flags win over a same-cycle clear
      db_q <= (db_q & ~db_clr) | (ring_in & busy_q[NCORE-1:0]);
      cp_q <= (cp_q & ~cp_clr) | (ack_in  & done_q[NCORE-1:0]);
    end
  end

  assign busy_mask_o = busy_q;
  assign done_mask_o = done_q;
  assign db_pend_o   = db_q;
  assign cp_pend_o   = cp_q;
  assign irq_o       = |{db_q, cp_q};
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_mbox_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 32,
  parameter int EXTW  = 30,
  parameter int MASKW = 8,
  parameter int OFFW  = 3 + $clog2(NCORE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    bus_req,
  input  logic [NCORE-1:0]    bus_we,
  input  logic [NCORE*OFFW-1:0] bus_addr,
  input  logic [NCORE*DW-1:0] bus_wdata,
  output logic [NCORE*DW-1:0] bus_rdata,
  output logic [NCORE-1:0]    irq
);
  localparam int CW = OFFW - 3;

  logic [NCORE-1:0][2:0]    grp;
  logic [NCORE-1:0][CW-1:0] idx;
  logic [NCORE-1:0]         wr_en, rd_en;
  logic [NCORE-1:0][DW-1:0] wdat;
  logic [NCORE-1:0][DW-1:0] rdata_q, rd_next;

  // storage and events indexed [src][dst] unless noted
  logic [NCORE-1:0][NCORE-1:0][DW-1:0]   msg_q;
  logic [NCORE-1:0][NCORE-1:0][EXTW-1:0] ext_q;
  logic [NCORE-1:0][NCORE-1:0] xinit_wr, xtgt_wr;
  logic [NCORE-1:0][NCORE-1:0] ring_to;   // [dst][src]
  logic [NCORE-1:0][NCORE-1:0] ack_from;  // [src][dst]
  logic [NCORE-1:0][NCORE-1:0] db_pend;   // [dst][src]
  logic [NCORE-1:0][NCORE-1:0] cp_pend;   // [src][dst]
  logic [NCORE-1:0][MASKW-1:0] busy_mask, done_mask;

  for (genvar p = 0; p < NCORE; p++) begin : g_port
    assign grp[p]   = bus_addr[p*OFFW+CW +: 3];
    assign idx[p]   = bus_addr[p*OFFW +: CW];
    assign wdat[p]  = bus_wdata[p*DW +: DW];
    assign wr_en[p] = bus_req[p] & bus_we[p];
    assign rd_en[p] = bus_req[p] & ~bus_we[p];
  end

  for (genvar s = 0; s < NCORE; s++) begin : g_src
    for (genvar d = 0; d < NCORE; d++) begin : g_dst
      logic init_wr, tgt_wr, ring_w, ack_w;
      assign init_wr = wr_en[s] && grp[s] == GRP_INIT  && idx[s] == CW'(d);
      assign tgt_wr  = wr_en[d] && grp[d] == GRP_TGT   && idx[d] == CW'(s);
      assign xinit_wr[s][d] = wr_en[s] && grp[s] == GRP_XINIT && idx[s] == CW'(d);
      assign xtgt_wr[s][d]  = wr_en[d] && grp[d] == GRP_XTGT  && idx[d] == CW'(s);

      doorbell_mbox_pair #(.DW(DW), .EXTW(EXTW)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_wr  (init_wr),
        .init_data(wdat[s]),
        .tgt_wr   (tgt_wr),
        .tgt_top  (wdat[d][DW-1]),
        .xinit_wr (xinit_wr[s][d]),
        .xtgt_wr  (xtgt_wr[s][d]),
        .tgt_ext  (wdat[d][EXTW-1:0]),
        .msg_o    (msg_q[s][d]),
        .ext_o    (ext_q[s][d]),
        .ring_o   (ring_w),
        .ack_o    (ack_w)
      );
      assign ring_to[d][s]  = ring_w;
      assign ack_from[s][d] = ack_w;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic ctl;
    assign ctl = wr_en[c] && grp[c] == GRP_CTRL;

    doorbell_mbox_core #(.NCORE(NCORE), .MASKW(MASKW)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .ring_in    (ring_to[c]),
      .ack_in     (ack_from[c]),
      .busy_wr    (ctl && idx[c] == CW'(CTL_BUSY)),
      .done_wr    (ctl && idx[c] == CW'(CTL_DONE)),
      .stat_wr    (ctl && idx[c] == CW'(CTL_STAT)),
      .mask_data  (wdat[c][MASKW-1:0]),
      .clr_data   (wdat[c][2*NCORE-1:0]),
      .busy_mask_o(busy_mask[c]),
      .done_mask_o(done_mask[c]),
      .db_pend_o  (db_pend[c]),
      .cp_pend_o  (cp_pend[c]),
      .irq_o      (irq[c])
    );

    always_comb begin
      rd_next[c] = '0;
      case (grp[c])
        GRP_TGT:   rd_next[c] = msg_q[idx[c]][c];
        GRP_INIT:  rd_next[c] = msg_q[c][idx[c]];
        GRP_XINIT: rd_next[c] = DW'(ext_q[c][idx[c]]);
        GRP_XTGT:  rd_next[c] = DW'(ext_q[idx[c]][c]);
        GRP_CTRL: begin
          if (idx[c] == CW'(CTL_BUSY))      rd_next[c] = DW'(busy_mask[c]);
          else if (idx[c] == CW'(CTL_DONE)) rd_next[c] = DW'(done_mask[c]);
          else if (idx[c] == CW'(CTL_STAT)) rd_next[c] = DW'({cp_pend[c], db_pend[c]});
        end
        default:   rd_next[c] = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q[c] <= '0;
      else if (rd_en[c]) rdata_q[c] <= rd_next[c];
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/doorbell_mbox_chk.sv
module doorbell_mbox_chk #(
  parameter int NCORE = 4,
  parameter int DW    = 32,
  parameter int EXTW  = 30,
  parameter int MASKW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic [NCORE-1:0][NCORE-1:0][DW-1:0]   msg_q,
  input logic [NCORE-1:0][NCORE-1:0][EXTW-1:0] ext_q,
  input logic [NCORE-1:0][NCORE-1:0] xinit_wr,
  input logic [NCORE-1:0][NCORE-1:0] xtgt_wr,
  input logic [NCORE-1:0][NCORE-1:0] ring_to,
  input logic [NCORE-1:0][NCORE-1:0] ack_from,
  input logic [NCORE-1:0][NCORE-1:0] db_pend,
  input logic [NCORE-1:0][NCORE-1:0] cp_pend,
  input logic [NCORE-1:0][MASKW-1:0] busy_mask,
  input logic [NCORE-1:0][MASKW-1:0] done_mask,
  input logic [NCORE-1:0] irq
);
  for (genvar s = 0; s < NCORE; s++) begin : g_s
    for (genvar d = 0; d < NCORE; d++) begin : g_d
      AST_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ack_from[s][d] |=> msg_q[s][d] == '0); // R4
      AST_RING_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ring_to[d][s] && busy_mask[d][s] |=> db_pend[d][s]); // R3
      AST_ACK_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_from[s][d] && done_mask[s][d] |=> cp_pend[s][d]); // R5
      AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_mask[d][s] && !db_pend[d][s] |=> !db_pend[d][s]); // R6
      AST_NO_RERING: assert property (@(posedge clk) disable iff (!rst_n)
        msg_q[s][d][DW-1] |-> !ring_to[d][s]); // R6
      AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xinit_wr[s][d] && !xtgt_wr[s][d] |=> $stable(ext_q[s][d])); // R7
    end
  end
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      db_pend[c] == '0 && cp_pend[c] == '0 |-> !irq[c]); // R8
  end
endmodule

bind doorbell_mbox doorbell_mbox_chk #(
  .NCORE(NCORE), .DW(DW), .EXTW(EXTW), .MASKW(MASKW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .msg_q    (msg_q),
  .ext_q    (ext_q),
  .xinit_wr (xinit_wr),
  .xtgt_wr  (xtgt_wr),
  .ring_to  (ring_to),
  .ack_from (ack_from),
  .db_pend  (db_pend),
  .cp_pend  (cp_pend),
  .busy_mask(busy_mask),
  .done_mask(done_mask),
  .irq      (irq)
);

// File: tb/doorbell_mbox_bench.sv
`timescale 1ns/1ps
module doorbell_mbox_bench;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int OW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req = '0;
  logic [NC-1:0]    we = '0;
  logic [NC*OW-1:0] addr = '0;
  logic [NC*DW-1:0] wdata = '0;
  logic [NC*DW-1:0] rdata;
  logic [NC-1:0]    irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  doorbell_mbox u_doorbell_mbox (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int c, bit w, int g, int i, logic [31:0] d);
    req[c] = 1'b1;
    we[c]  = w;
    addr[c*OW +: OW] = {g[2:0], i[1:0]};
    wdata[c*DW +: DW] = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    req = '0;
    we  = '0;
  endtask

  task automatic wr(int c, int g, int i, logic [31:0] d);
    drive(c, 1'b1, g, i, d);
    step();
  endtask

  task automatic rd(int c, int g, int i, output logic [31:0] v);
    drive(c, 1'b0, g, i, 32'h0);
    step();
    v = rdata[c*DW +: DW];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, pat, exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < 5; g++)
        for (int i = 0; i < NC; i++) begin
          rd(c, g, i, v);
          chk("R1 reset read", v, 32'h0);
        end
    rd(0, 5, 0, v); chk("R10 unmapped grp5", v, 32'h0);
    rd(1, 7, 3, v); chk("R10 unmapped grp7", v, 32'h0);
    rd(2, 4, 3, v); chk("R10 ctrl idx3", v, 32'h0);

    for (int c = 0; c < NC; c++) begin
      wr(c, 4, 0, 32'hFF);
      wr(c, 4, 1, 32'hFF);
      rd(c, 4, 0, v); chk("R6 busy mask readback", v, 32'hFF);
      rd(c, 4, 1, v); chk("R6 done mask readback", v, 32'hFF);
    end

    // full pair sweep
    for (int s = 0; s < NC; s++)
      for (int d = 0; d < NC; d++) begin
        pat = {1'b1, 31'(32'h1357_9BDF ^ (32'(s * 16 + d) * 32'h0101_0101))};
        wr(s, 1, d, pat);
        chk("R3 irq rises at dst", {28'h0, irq}, 32'(1 << d));
        rd(d, 0, s, v); chk("R2 target view", v, pat);
        rd(s, 1, d, v); chk("R2 initiator view", v, pat);
        rd(d, 4, 2, v); chk("R3 doorbell status", v, 32'(1 << s));
        wr(d, 0, s, 32'h8000_0000);
        rd(s, 1, d, v); chk("R4 ack clears word", v, 32'h0);
        exp = 32'(1 << (4 + d));
        if (s == d) exp |= 32'(1 << s);
        rd(s, 4, 2, v); chk("R5 completion status", v, exp);
        chk("R8 irq both cores", {28'h0, irq}, 32'((1 << s) | (1 << d)));
        wr(d, 4, 2, 32'hFF);
        wr(s, 4, 2, 32'hFF);
        chk("R8 irq after clear", {28'h0, irq}, 32'h0);
      end

    // masks block flags
    wr(2, 4, 0, 32'h0);
    wr(0, 1, 2, 32'h8000_0005);
    rd(2, 4, 2, v); chk("R6 busy masked status", v, 32'h0);
    chk("R6 busy masked irq", {28'h0, irq}, 32'h0);
    wr(0, 4, 1, 32'h0);
    wr(2, 0, 0, 32'h8000_0000);
    rd(0, 4, 2, v); chk("R6 done masked status", v, 32'h0);
    rd(0, 1, 2, v); chk("R4 masked ack still clears", v, 32'h0);
    wr(2, 4, 0, 32'hFF);
    wr(0, 4, 1, 32'hFF);

    // no re-ring on busy word, target write without bit 31 ignored
    wr(1, 1, 3, 32'h8000_0001);
    rd(3, 4, 2, v); chk("R3 ring 1 to 3", v, 32'h2);
    wr(3, 4, 2, 32'hFF);
    wr(1, 1, 3, 32'h8000_0002);
    rd(3, 4, 2, v); chk("R6 busy word no re-ring", v, 32'h0);
    rd(3, 0, 1, v); chk("R2 overwrite visible", v, 32'h8000_0002);
    wr(3, 0, 1, 32'h0000_0055);
    rd(1, 1, 3, v); chk("R4 target write bit31 clear ignored", v, 32'h8000_0002);
    wr(3, 0, 1, 32'h8000_0000);
    wr(1, 4, 2, 32'hFF);
    chk("R8 irq idle", {28'h0, irq}, 32'h0);

    // extension words, both directions
    for (int s = 0; s < NC; s++)
      for (int d = 0; d < NC; d++) begin
        pat = 32'hFFFF_FFFF ^ (32'(s * 4 + d) * 32'h0011_2233);
        wr(s, 2, d, pat);
        rd(d, 3, s, v); chk("R7 ext target view", v, pat & 32'h3FFF_FFFF);
        wr(d, 3, s, ~pat);
        rd(s, 2, d, v); chk("R7 ext initiator view", v, ~pat & 32'h3FFF_FFFF);
        rd(s, 1, d, v); chk("R7 ext leaves message", v, 32'h0);
        chk("R7 ext no irq", {28'h0, irq}, 32'h0);
      end

    // same-cycle initiator write and acknowledge
    drive(1, 1'b1, 1, 2, 32'h8000_0011);
    drive(2, 1'b1, 0, 1, 32'h8000_0000);
    step();
    rd(1, 1, 2, v); chk("R9 collision word zero", v, 32'h0);
    rd(2, 4, 2, v); chk("R9 collision no doorbell", v, 32'h0);
    rd(1, 4, 2, v); chk("R9 collision completion", v, 32'h40);
    wr(1, 4, 2, 32'hFF);

    // flag set wins over same-cycle clear
    drive(0, 1'b1, 1, 3, 32'h8000_0001);
    drive(3, 1'b1, 4, 2, 32'hFF);
    step();
    rd(3, 4, 2, v); chk("R8 set beats clear", v, 32'h1);
    chk("R8 irq held", {28'h0, irq}, 32'h8);
    wr(3, 0, 0, 32'h8000_0000);
    wr(3, 4, 2, 32'hFF);
    wr(0, 4, 2, 32'hFF);
    chk("R8 all clear", {28'h0, irq}, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule